// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the arithmetic-logic unit for an 8-bit datapath. Every cycle it combines an accumulator operand, a memory operand and an incoming carry under a 4-bit operation code. It produces a result byte and a candidate set of negative, zero, carry and overflow flags. Producing the result takes no clock. The status flags are held in a small register that is written on the rising clock edge.

Two controls decide what is committed in a cycle. A write-enable gates both the result-write strobe and any flag update. A per-flag mask selects which of the four flags may be written. Each operation also carries its own set of affected flags, and a flag outside that set keeps its value whatever the mask says. Compare and bit test only set flags; they never raise the result-write strobe.

Operations that take one operand (the shifts, the rotates, increment and decrement) act on `mem_i`. To apply one of them to the accumulator, the caller routes the accumulator value onto that port.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add with carry) gives result = (A + M + carry_i) mod 256, sets C when the unsigned sum exceeds 255, and drives N from result bit 7 and Z from result == 0.
- R2: Opcode 1 (subtract with borrow) gives result = (A − M − (1 − carry_i)) mod 256 and sets C to 1 when no borrow occurred and to 0 when a borrow occurred. N and Z follow the result.
- R3: For opcodes 0 and 1, V is set exactly when the signed (two's complement) add or subtract falls outside −128..127.
- R4: Opcode 5 (compare) sets C when A ≥ M unsigned, sets Z when A == M, and sets N from bit 7 of (A − M) mod 256. It leaves V unchanged and never raises result_we_o.
- R5: Opcode 6 (bit test) sets N from M bit 7, V from M bit 6 and Z when (A AND M) == 0. It leaves C unchanged and never raises result_we_o.
- R6: Opcode 7 (shift left) moves M bit 7 into C and fills bit 0 with 0. Opcode 8 (shift right) moves M bit 0 into C and fills bit 7 with 0. Both set N and Z from the result and leave V unchanged.
- R7: Opcode 9 (rotate left) fills bit 0 with carry_i and moves M bit 7 into C. Opcode 10 (rotate right) fills bit 7 with carry_i and moves M bit 0 into C. Both set N and Z from the result and leave V unchanged.
- R8: Opcode 11 (increment) and opcode 12 (decrement) give M + 1 and M − 1, wrapping modulo 256. They update only N and Z and leave C and V unchanged.
- R9: Opcodes 2, 3 and 4 give A AND M, A OR M and A XOR M. They update only N and Z.
- R10: flags_o and flag_mask_i share one bit layout: bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. A flag is written on a rising edge only when wr_en_i is 1, its mask bit is 1 and the operation affects it; otherwise it holds its value.
- R11: When wr_en_i is 0, result_we_o is 0 and all flags hold.
- R12: A synchronous active-high rst clears all four flags to 0 at the next rising edge.
- R13: Opcodes 13 to 15 give result 0, never raise result_we_o and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator operand A |
| mem_i | input | 8 | Memory operand M; sole operand of the one-operand operations |
| carry_i | input | 1 | Incoming carry used by add, subtract and the rotates |
| wr_en_i | input | 1 | Commit enable for the result strobe and the flag update |
| flag_mask_i | input | 4 | Per-flag write mask {N,Z,C,V} |
| result_o | output | 8 | Combinational result byte |
| result_we_o | output | 1 | High when the result is to be written back |
| flags_o | output | 4 | Registered status flags {N,Z,C,V} |

## Verification
Within a single cycle the block both sets the result-write strobe and commits flags, and the two follow different rules. Compare and bit test update flags while the strobe stays low. A partial mask, or an operation that affects fewer than four flags, updates only some flags and leaves the rest in place. The bench runs each operation with full masks, partial masks and write-enable low, and after each run it checks the strobe in the same cycle and all four flags one edge later. Each step is judged against a flag model that keeps the old value of every flag that was masked off, not affected, or not enabled.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_AND = 4'd2,
        OP_ORA = 4'd3,
        OP_EOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_ASL = 4'd7,
        OP_LSR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Flags an operation is allowed to touch, in {N,Z,C,V} order.
    function automatic logic [NUM_FLAGS-1:0] affected_flags(input logic [3:0] code);
        logic [NUM_FLAGS-1:0] sel;
        case (code)
            OP_ADC, OP_SBC:                  sel = 4'b1111;
            OP_AND, OP_ORA, OP_EOR:          sel = 4'b1100;
            OP_INC, OP_DEC:                  sel = 4'b1100;
            OP_CMP:                          sel = 4'b1110;
            OP_BIT:                          sel = 4'b1101;
            OP_ASL, OP_LSR, OP_ROL, OP_ROR:  sel = 4'b1110;
            default:                         sel = 4'b0000;
        endcase
        return sel;
    endfunction

    function automatic logic writes_result(input logic [3:0] code);
        logic w;
        case (code)
            OP_CMP, OP_BIT: w = 1'b0;
            OP_ADC, OP_SBC, OP_AND, OP_ORA, OP_EOR,
            OP_ASL, OP_LSR, OP_ROL, OP_ROR,
            OP_INC, OP_DEC: w = 1'b1;
            default:        w = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
        sum_o    = wide_sum[DATA_W-1:0];
        cout_o   = wide_sum[DATA_W];
        ovf_o    = (x_i[MSB] == y_i[MSB]) && (wide_sum[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              carry_i,
    input  logic              left_i,
    input  logic              rotate_i,
    output logic [DATA_W-1:0] val_o,
    output logic              carry_o
);
    localparam int MSB = DATA_W - 1;

    logic fill;

    always_comb begin
        fill = rotate_i & carry_i;
        if (left_i) begin
            val_o   = {val_i[MSB-1:0], fill};
            carry_o = val_i[MSB];
        end else begin
            val_o   = {fill, val_i[MSB:1]};
            carry_o = val_i[0];
        end
    end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] or_o,
    output logic [DATA_W-1:0] xor_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
    end
endmodule

// File: rtl/byte_alu_flagreg.sv
module byte_alu_flagreg #(
    parameter int NFLAGS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAGS-1:0] commit_i,
    input  logic [NFLAGS-1:0] next_i,
    output logic [NFLAGS-1:0] flags_o
);
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_o[g] <= 1'b0;
            end else if (commit_i[g]) begin
                flags_o[g] <= next_i[g];
            end
        end

        // R10: an uncommitted flag keeps its value
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            !commit_i[g] |=> $stable(flags_o[g]));
    end

    // R12: reset clears the flags
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (flags_o == '0));
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic              carry_i,
    input  logic              wr_en_i,
    input  logic [3:0]        flag_mask_i,
    output logic [DATA_W-1:0] result_o,
    output logic              result_we_o,
    output logic [3:0]        flags_o
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ZERO_W = '0;
    localparam logic [DATA_W-1:0] ONES_W = '1;

    // arithmetic operand steering
    logic [DATA_W-1:0] ar_x, ar_y, ar_sum;
    logic              ar_ci, ar_co, ar_ovf;

    always_comb begin
        ar_x  = acc_i;
        ar_y  = mem_i;
        ar_ci = carry_i;
        case (op_i)
            OP_SBC: begin ar_y = ~mem_i; end
            OP_CMP: begin ar_y = ~mem_i; ar_ci = 1'b1; end
            OP_INC: begin ar_x = mem_i; ar_y = ZERO_W; ar_ci = 1'b1; end
            OP_DEC: begin ar_x = mem_i; ar_y = ONES_W; ar_ci = 1'b0; end
            default: ;
        endcase
    end

    byte_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .x_i    (ar_x),
        .y_i    (ar_y),
        .cin_i  (ar_ci),
        .sum_o  (ar_sum),
        .cout_o (ar_co),
        .ovf_o  (ar_ovf)
    );

    // shifter
    logic              sh_left, sh_rot, sh_co;
    logic [DATA_W-1:0] sh_val;

    assign sh_left = (op_i == OP_ASL) || (op_i == OP_ROL);
    assign sh_rot  = (op_i == OP_ROL) || (op_i == OP_ROR);

    byte_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .val_i    (mem_i),
        .carry_i  (carry_i),
        .left_i   (sh_left),
        .rotate_i (sh_rot),
        .val_o    (sh_val),
        .carry_o  (sh_co)
    );

    // bitwise logic
    logic [DATA_W-1:0] lg_and, lg_or, lg_xor;

    byte_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (acc_i),
        .b_i   (mem_i),
        .and_o (lg_and),
        .or_o  (lg_or),
        .xor_o (lg_xor)
    );

    // result and candidate flags
    flags_t next_flags;

    always_comb begin
        case (op_i)
            OP_ADC, OP_SBC, OP_INC, OP_DEC: result_o = ar_sum;
            OP_AND:                         result_o = lg_and;
            OP_ORA:                         result_o = lg_or;
            OP_EOR:                         result_o = lg_xor;
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: result_o = sh_val;
            default:                        result_o = ZERO_W;
        endcase

        next_flags.n = result_o[MSB];
        next_flags.z = (result_o == ZERO_W);
        next_flags.c = sh_co;
        next_flags.v = ar_ovf;
        case (op_i)
            OP_ADC, OP_SBC: next_flags.c = ar_co;
            OP_CMP: begin
                next_flags.n = ar_sum[MSB];
                next_flags.z = (ar_sum == ZERO_W);
                next_flags.c = ar_co;
            end
            OP_BIT: begin
                next_flags.n = mem_i[MSB];
                next_flags.v = mem_i[MSB-1];
                next_flags.z = (lg_and == ZERO_W);
            end
            default: ;
        endcase
    end

    logic [NUM_FLAGS-1:0] commit;

    assign commit      = wr_en_i ? (flag_mask_i & affected_flags(op_i)) : '0;
    assign result_we_o = wr_en_i & writes_result(op_i);

    byte_alu_flagreg #(.NFLAGS(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .next_i   (next_flags),
        .flags_o  (flags_o)
    );

    // R4: compare never writes a result
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP) |-> !result_we_o);

    // R5: bit test never writes a result
    a_r5_bit_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BIT) |-> !result_we_o);

    // R5: N takes operand bit 7 on a committed bit test
    a_r5_bit_n: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i == OP_BIT && flag_mask_i[FLAG_N])
        |=> (flags_o[FLAG_N] == $past(mem_i[MSB])));

    // R1: an add without carry-in that carries out has wrapped below A
    a_r1_adc_wrap: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADC && !carry_i && ar_co) |-> (result_o < acc_i));

    // R8: increment and decrement keep C and V
    a_r8_incdec_cv: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INC || op_i == OP_DEC)
        |=> ($stable(flags_o[FLAG_C]) && $stable(flags_o[FLAG_V])));

    // R11: disabled write-enable freezes all flags
    a_r11_wr_off: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(flags_o));

    // R13: unused codes commit nothing
    a_r13_undef: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_DEC) |-> (!result_we_o && result_o == ZERO_W));
endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] mem_i = 8'd0;
    logic       carry_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] flag_mask_i = 4'd0;
    logic [7:0] result_o;
    logic       result_we_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_flags = 4'd0;

    always #10 clk = ~clk;

    byte_alu u_byte_alu (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op_i),
        .acc_i       (acc_i),
        .mem_i       (mem_i),
        .carry_i     (carry_i),
        .wr_en_i     (wr_en_i),
        .flag_mask_i (flag_mask_i),
        .result_o    (result_o),
        .result_we_o (result_we_o),
        .flags_o     (flags_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference built from the requirement text. Flag vectors are {N,Z,C,V}.
    function automatic void model(input logic [3:0] op, input int a, input int m, input int c,
                                  output int res, output logic [3:0] nf,
                                  output logic [3:0] aff, output logic wr);
        int sa, sm, t;
        sa = (a >= 128) ? a - 256 : a;
        sm = (m >= 128) ? m - 256 : m;
        res = 0; nf = 4'b0000; aff = 4'b0000; wr = 1'b0;
        case (op)
            4'd0: begin
                t = a + m + c; res = t % 256;
                nf[1] = (t > 255);
                t = sa + sm + c; nf[0] = (t > 127) || (t < -128);
                aff = 4'b1111; wr = 1'b1;
            end
            4'd1: begin
                t = a - m - (1 - c); res = (t + 512) % 256;
                nf[1] = (t >= 0);
                t = sa - sm - (1 - c); nf[0] = (t > 127) || (t < -128);
                aff = 4'b1111; wr = 1'b1;
            end
            4'd2: begin res = a & m; aff = 4'b1100; wr = 1'b1; end
            4'd3: begin res = a | m; aff = 4'b1100; wr = 1'b1; end
            4'd4: begin res = a ^ m; aff = 4'b1100; wr = 1'b1; end
            4'd5: aff = 4'b1110;
            4'd6: aff = 4'b1101;
            4'd7: begin res = (m * 2) % 256; nf[1] = (m >= 128); aff = 4'b1110; wr = 1'b1; end
            4'd8: begin res = m / 2; nf[1] = m % 2; aff = 4'b1110; wr = 1'b1; end
            4'd9: begin res = (m * 2) % 256 + c; nf[1] = (m >= 128); aff = 4'b1110; wr = 1'b1; end
            4'd10: begin res = m / 2 + 128 * c; nf[1] = m % 2; aff = 4'b1110; wr = 1'b1; end
            4'd11: begin res = (m + 1) % 256; aff = 4'b1100; wr = 1'b1; end
            4'd12: begin res = (m + 255) % 256; aff = 4'b1100; wr = 1'b1; end
            default: ;
        endcase
        nf[3] = (res >= 128);
        nf[2] = (res == 0);
        if (op == 4'd5) begin
            t = (a - m + 256) % 256;
            nf[3] = (t >= 128); nf[2] = (a == m); nf[1] = (a >= m);
        end
        if (op == 4'd6) begin
            nf[3] = (m >= 128); nf[0] = ((m / 64) % 2 == 1); nf[2] = ((a & m) == 0);
        end
    endfunction

    // Applies one operation just after a falling edge and checks the
    // combinational outputs, then the flags after the next rising edge.
    task automatic step(input string tag, input logic [3:0] op, input int a, input int m,
                        input int c, input logic [3:0] mask, input logic we);
        int er; logic [3:0] nf, aff; logic ew;
        op_i = op; acc_i = a[7:0]; mem_i = m[7:0]; carry_i = c[0];
        flag_mask_i = mask; wr_en_i = we;
        model(op, a, m, c, er, nf, aff, ew);
        #2;
        if (ew || op > 4'd12) check(tag, "result", int'(result_o), er);
        check(tag, "result_we", int'(result_we_o), int'(ew & we));
        for (int i = 0; i < 4; i++)
            if (we && mask[i] && aff[i]) exp_flags[i] = nf[i];
        @(negedge clk);
        check(tag, "flags", int'(flags_o), int'(exp_flags));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R12", "flags after reset", int'(flags_o), 0);
        rst = 1'b0;
        exp_flags = 4'd0;
    endtask

    task automatic t_adc();
        step("R1 R3", 4'd0, 8'h50, 8'h50, 0, 4'hF, 1'b1);
        step("R1", 4'd0, 8'hFF, 8'h01, 0, 4'hF, 1'b1);
        step("R1", 4'd0, 8'hFF, 8'hFF, 1, 4'hF, 1'b1);
        step("R1", 4'd0, 8'h10, 8'h20, 1, 4'hF, 1'b1);
        step("R3", 4'd0, 8'h80, 8'h80, 0, 4'hF, 1'b1);
    endtask

    task automatic t_sbc();
        step("R2", 4'd1, 8'h50, 8'hF0, 1, 4'hF, 1'b1);
        step("R2", 4'd1, 8'h50, 8'h30, 1, 4'hF, 1'b1);
        step("R2", 4'd1, 8'h00, 8'h00, 0, 4'hF, 1'b1);
        step("R2 R3", 4'd1, 8'h80, 8'h01, 1, 4'hF, 1'b1);
        step("R3", 4'd1, 8'h7F, 8'hFF, 1, 4'hF, 1'b1);
    endtask

    task automatic t_cmp();
        step("R4 setup V", 4'd0, 8'h50, 8'h50, 0, 4'hF, 1'b1);
        step("R4", 4'd5, 8'h40, 8'h40, 0, 4'hF, 1'b1);
        step("R4", 4'd5, 8'h41, 8'h10, 0, 4'hF, 1'b1);
        step("R4", 4'd5, 8'h10, 8'h41, 1, 4'hF, 1'b1);
    endtask

    task automatic t_bit();
        step("R5 setup C", 4'd1, 8'h05, 8'h01, 1, 4'hF, 1'b1);
        step("R5", 4'd6, 8'h0F, 8'hC0, 0, 4'hF, 1'b1);
        step("R5", 4'd6, 8'hFF, 8'h01, 0, 4'hF, 1'b1);
        step("R5", 4'd6, 8'h20, 8'h60, 0, 4'hF, 1'b1);
    endtask

    task automatic t_shift();
        step("R6", 4'd7, 0, 8'h81, 1, 4'hF, 1'b1);
        step("R6", 4'd7, 0, 8'h40, 1, 4'hF, 1'b1);
        step("R6", 4'd8, 0, 8'h01, 1, 4'hF, 1'b1);
        step("R6", 4'd8, 0, 8'hFE, 0, 4'hF, 1'b1);
    endtask

    task automatic t_rotate();
        step("R7", 4'd9, 0, 8'h80, 1, 4'hF, 1'b1);
        step("R7", 4'd9, 0, 8'h80, 0, 4'hF, 1'b1);
        step("R7", 4'd10, 0, 8'h01, 1, 4'hF, 1'b1);
        step("R7", 4'd10, 0, 8'h02, 0, 4'hF, 1'b1);
    endtask

    task automatic t_incdec();
        step("R8 setup CV", 4'd1, 8'h80, 8'h01, 1, 4'hF, 1'b1);
        step("R8", 4'd11, 0, 8'hFF, 0, 4'hF, 1'b1);
        step("R8", 4'd11, 0, 8'h7F, 0, 4'hF, 1'b1);
        step("R8", 4'd12, 0, 8'h00, 0, 4'hF, 1'b1);
        step("R8", 4'd12, 0, 8'h01, 0, 4'hF, 1'b1);
    endtask

    task automatic t_logic();
        step("R9", 4'd2, 8'hF0, 8'h0F, 1, 4'hF, 1'b1);
        step("R9", 4'd3, 8'h80, 8'h01, 0, 4'hF, 1'b1);
        step("R9", 4'd4, 8'hAA, 8'h55, 0, 4'hF, 1'b1);
    endtask

    task automatic t_mask();
        step("R10 clear", 4'd0, 8'h01, 8'h01, 0, 4'hF, 1'b1);
        step("R10 N,C", 4'd0, 8'hFF, 8'h81, 0, 4'b1010, 1'b1);
        step("R10 Z,V", 4'd0, 8'h80, 8'h80, 0, 4'b0101, 1'b1);
        step("R10 none", 4'd1, 8'h00, 8'h01, 0, 4'b0000, 1'b1);
    endtask

    task automatic t_wr_off();
        step("R11", 4'd0, 8'hFF, 8'h01, 0, 4'hF, 1'b0);
        step("R11", 4'd7, 0, 8'hFF, 0, 4'hF, 1'b0);
    endtask

    task automatic t_undef();
        step("R13", 4'd13, 8'hFF, 8'hFF, 1, 4'hF, 1'b1);
        step("R13", 4'd15, 8'h00, 8'h00, 0, 4'hF, 1'b1);
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_adc();
        t_sbc();
        t_cmp();
        t_bit();
        t_shift();
        t_rotate();
        t_incdec();
        t_logic();
        t_mask();
        t_wr_off();
        t_undef();
        step("R12 setup", 4'd0, 8'hFF, 8'hFF, 1, 4'hF, 1'b1);
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule